// File: doc/BRIEF.md
# Indirect DLL Calibration Sequencer

This block programs a DLL calibration register file that can only be reached through an indirect access port. The port has three parts. A control word carries a 6-bit target index and a direction bit. A write-data word holds the value to write. A one-cycle start strobe launches the access. Read results come back on a read-data bus. The block never touches the register file directly: every step is one indirect access, launched by a strobe.

A host asks for one of two sequences through a valid/ready request channel.

The enable sequence does four things in order:
1. It unlocks the register file.
2. It reads a raw calibration code.
3. It maps the code through a computed 32-entry table and writes the result back as a manual calibration value.
4. It loads a small offset register from configuration.

The disable sequence unlocks the register file, clears the manual calibration value and zeroes the offset.

The enable sequence is gated. It runs only when all three of these hold:
- adjustment is switched on;
- a table is present;
- a pending-adjust flag is set.

The pending flag is set by a pulse input and clears when an enable sequence completes. `busy` and `done` report progress.

Request channel rules:
- `req_ready` is high only while the block is idle.
- A request is taken on a cycle where both `req_valid` and `req_ready` are high.
- While the block is busy, `req_ready` stays low and back-pressures the host.
- A host that drops `req_valid` before `req_ready` returns leaves no trace: nothing is queued.

Top module: `dcal_seq`

## Requirements
- R1: `port_ctl` carries the target index in bits [5:0] and the direction in bit 8 (1 = read, 0 = write); bits [7:6] are 0. `port_ctl` and `port_wdata` are set up before the strobe and stay unchanged while it is high.
- R2: Each access raises `port_strobe` for exactly one cycle. For a read, `port_rdata` is taken in the cycle that follows the cycle in which the strobe is high, and at no other time.
- R3: An enable sequence makes exactly three accesses, in this order: write 0xA5000000 to index 0x00, read index 0x26, write index 0x22.
- R4: The raw code is bits [4:0] of the word read from index 0x26. The table entry for code c is (c*3)/4 + 2, using integer division and saturating at 31. The word written to 0x22 is that entry ORed with 0x80 (manual-mode flag at bit 7).
- R5: `offset_q` takes `offset_cfg` only after the manual calibration write of an enable sequence. It changes at no other step of that sequence.
- R6: A disable sequence makes exactly two accesses: write 0xA5000000 to 0x00, then write 0 to 0x22. It then sets `offset_q` to 0.
- R7: An enable request is accepted in every case. When `adjust_en`, `table_present` or `pending` is low, the request completes with `done` and no access, and it leaves `offset_q`, `pending` and the register file unchanged.
- R8: A `pend_set` pulse sets `pending`. `pending` clears when an enable sequence completes its offset step. If `pend_set` arrives in that same cycle, the set wins.
- R9: `busy` is high from the cycle after a request is accepted through the cycle in which `done` is high. `req_ready` is low while `busy` is high, and a request offered while busy is not taken.
- R10: After reset, `busy`, `done`, `port_strobe`, `pending` and `offset_q` are 0, and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host offers a request |
| req_enable | input | 1 | 1 = enable sequence, 0 = disable sequence |
| req_ready | output | 1 | High when a request can be taken |
| adjust_en | input | 1 | Adjustment switched on |
| table_present | input | 1 | A calibration table is available |
| pend_set | input | 1 | Pulse that marks an adjustment as pending |
| offset_cfg | input | 2 | Offset value loaded by the enable sequence |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion flag |
| pending | output | 1 | Pending-adjust flag |
| offset_q | output | 2 | Offset register |
| port_ctl | output | 9 | Indirect control: index [5:0], read flag [8] |
| port_wdata | output | 32 | Indirect write data |
| port_strobe | output | 1 | Indirect access start strobe |
| port_rdata | input | 32 | Indirect read data |

## Verification
The enable sequence is run with raw words whose low five bits cover 0, 1, 5, 10, 16 and 31, and whose upper bits are junk. Each run also uses a different offset value. Together these runs show that the code is masked, that the table entry is correct at both ends of the index range, and that the offset follows the configuration. The model register file drives its read bus with a junk word in every cycle except the one after the strobe. A design that samples in the wrong cycle therefore writes a different manual value. The model also refuses a write to 0x22 unless an unlock came first, so an access issued out of order shows up as a missing calibration value. The gated cases are tried one input at a time (pending clear, adjustment off, table absent) to separate each gating input. A request offered while a disable sequence is busy shows whether the block drops it or runs it later.

// File: rtl/dcal_pkg.sv
package dcal_pkg;
  localparam int unsigned DCAL_IDX_W    = 6;
  localparam int unsigned DCAL_CTL_W    = 9;
  localparam int unsigned DCAL_DIR_BIT  = 8;
  localparam int unsigned DCAL_FLAG_BIT = 7;

  localparam logic [DCAL_IDX_W-1:0] IDX_UNLOCK = 6'h00;
  localparam logic [DCAL_IDX_W-1:0] IDX_RAW    = 6'h26;
  localparam logic [DCAL_IDX_W-1:0] IDX_MANUAL = 6'h22;
  localparam logic [31:0]           UNLOCK_KEY = 32'hA500_0000;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_UNLOCK, SQ_RAW, SQ_MANUAL, SQ_ZERO, SQ_OFFSET, SQ_FINISH
  } sq_state_t;

  typedef enum logic [1:0] {
    PD_IDLE, PD_ARM, PD_FIRE, PD_SETTLE
  } pd_state_t;
endpackage

// File: rtl/dcal_lut.sv
module dcal_lut #(
  parameter int CODE_W  = 5,
  parameter int ENTRY_W = 5,
  parameter int MUL     = 3,
  parameter int SHR     = 2,
  parameter int BIAS    = 2
) (
  input  logic [CODE_W-1:0]  code,
  output logic [ENTRY_W-1:0] entry
);
  localparam int DEPTH     = 1 << CODE_W;
  localparam int ENTRY_MAX = (1 << ENTRY_W) - 1;

  function automatic logic [ENTRY_W-1:0] calc(input int idx);
    int v;
    v = ((idx * MUL) >> SHR) + BIAS;
    if (v > ENTRY_MAX) v = ENTRY_MAX;
    return ENTRY_W'(v);
  endfunction

  logic [ENTRY_W-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign rom[g] = calc(g);
  end

  assign entry = rom[code];
endmodule

// File: rtl/dcal_port_drv.sv
module dcal_port_drv
  import dcal_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  op_go,
  input  logic                  op_read,
  input  logic [DCAL_IDX_W-1:0] op_idx,
  input  logic [DATA_W-1:0]     op_wdata,
  output logic                  op_done,
  output logic [DATA_W-1:0]     op_rdata,
  output logic [DCAL_CTL_W-1:0] port_ctl,
  output logic [DATA_W-1:0]     port_wdata,
  output logic                  port_strobe,
  input  logic [DATA_W-1:0]     port_rdata
);
  pd_state_t             st;
  logic [DCAL_CTL_W-1:0] ctl_n;

  always_comb begin
    ctl_n = '0;
    ctl_n[DCAL_IDX_W-1:0] = op_idx;
    ctl_n[DCAL_DIR_BIT]   = op_read;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= PD_IDLE;
      port_ctl    <= '0;
      port_wdata  <= '0;
      port_strobe <= 1'b0;
      op_done     <= 1'b0;
      op_rdata    <= '0;
    end else begin
      op_done <= 1'b0;
      unique case (st)
        PD_IDLE: if (op_go) begin
          port_ctl <= ctl_n;
          if (!op_read) port_wdata <= op_wdata;
          st <= PD_ARM;
        end
        PD_ARM: begin
          port_strobe <= 1'b1;
          st          <= PD_FIRE;
        end
        PD_FIRE: begin
          port_strobe <= 1'b0;
          st          <= PD_SETTLE;
        end
        PD_SETTLE: begin
          op_rdata <= port_rdata;
          op_done  <= 1'b1;
          st       <= PD_IDLE;
        end
        default: st <= PD_IDLE;
      endcase
    end
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    port_strobe |=> !port_strobe); // R2
  AST_GO_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    op_go |-> (st == PD_IDLE)); // R2
  AST_CTL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    port_strobe |-> ($stable(port_ctl) && $stable(port_wdata))); // R1
endmodule

// File: rtl/dcal_seq.sv
module dcal_seq
  import dcal_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int OFFS_W   = 2,
  parameter int CODE_W   = 5,
  parameter int LUT_MUL  = 3,
  parameter int LUT_SHR  = 2,
  parameter int LUT_BIAS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_enable,
  output logic                  req_ready,
  input  logic                  adjust_en,
  input  logic                  table_present,
  input  logic                  pend_set,
  input  logic [OFFS_W-1:0]     offset_cfg,
  output logic                  busy,
  output logic                  done,
  output logic                  pending,
  output logic [OFFS_W-1:0]     offset_q,
  output logic [DCAL_CTL_W-1:0] port_ctl,
  output logic [DATA_W-1:0]     port_wdata,
  output logic                  port_strobe,
  input  logic [DATA_W-1:0]     port_rdata
);
  sq_state_t             st;
  logic                  mode_en_q;
  logic                  issued;
  logic [CODE_W-1:0]     code_q;
  logic [CODE_W-1:0]     entry;
  logic                  is_access;
  logic                  op_go, op_read, op_done;
  logic [DCAL_IDX_W-1:0] op_idx;
  logic [DATA_W-1:0]     op_wdata, op_rdata, manual_word;
  logic                  allowed;
  logic                  unused_rdata_hi;

  assign unused_rdata_hi = ^op_rdata[DATA_W-1:CODE_W];

  dcal_lut #(.CODE_W(CODE_W), .ENTRY_W(CODE_W), .MUL(LUT_MUL),
             .SHR(LUT_SHR), .BIAS(LUT_BIAS)) u_lut (
    .code (code_q),
    .entry(entry)
  );

  always_comb begin
    manual_word = '0;
    manual_word[CODE_W-1:0]    = entry;
    manual_word[DCAL_FLAG_BIT] = 1'b1;
  end

  always_comb begin
    op_read  = 1'b0;
    op_idx   = IDX_UNLOCK;
    op_wdata = DATA_W'(UNLOCK_KEY);
    unique case (st)
      SQ_RAW:    begin op_read = 1'b1; op_idx = IDX_RAW; op_wdata = '0; end
      SQ_MANUAL: begin op_idx = IDX_MANUAL; op_wdata = manual_word; end
      SQ_ZERO:   begin op_idx = IDX_MANUAL; op_wdata = '0; end
      default:   ;
    endcase
  end

  assign is_access = (st == SQ_UNLOCK) || (st == SQ_RAW) ||
                     (st == SQ_MANUAL) || (st == SQ_ZERO);
  assign op_go     = is_access && !issued;
  assign allowed   = adjust_en && table_present && pending;
  assign busy      = (st != SQ_IDLE);
  assign req_ready = (st == SQ_IDLE);
  assign done      = (st == SQ_FINISH);

  dcal_port_drv #(.DATA_W(DATA_W)) u_drv (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_go      (op_go),
    .op_read    (op_read),
    .op_idx     (op_idx),
    .op_wdata   (op_wdata),
    .op_done    (op_done),
    .op_rdata   (op_rdata),
    .port_ctl   (port_ctl),
    .port_wdata (port_wdata),
    .port_strobe(port_strobe),
    .port_rdata (port_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         issued <= 1'b0;
    else if (op_go)     issued <= 1'b1;
    else if (op_done)   issued <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= SQ_IDLE;
      mode_en_q <= 1'b0;
      code_q    <= '0;
      offset_q  <= '0;
    end else begin
      unique case (st)
        SQ_IDLE: if (req_valid) begin
          mode_en_q <= req_enable;
          st        <= (req_enable && !allowed) ? SQ_FINISH : SQ_UNLOCK;
        end
        SQ_UNLOCK: if (issued && op_done) st <= mode_en_q ? SQ_RAW : SQ_ZERO;
        SQ_RAW: if (issued && op_done) begin
          code_q <= op_rdata[CODE_W-1:0];
          st     <= SQ_MANUAL;
        end
        SQ_MANUAL: if (issued && op_done) st <= SQ_OFFSET;
        SQ_ZERO:   if (issued && op_done) st <= SQ_OFFSET;
        SQ_OFFSET: begin
          offset_q <= mode_en_q ? offset_cfg : '0;
          st       <= SQ_FINISH;
        end
        SQ_FINISH: st <= SQ_IDLE;
        default:   st <= SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                              pending <= 1'b0;
    else if (pend_set)                       pending <= 1'b1;
    else if (st == SQ_OFFSET && mode_en_q)   pending <= 1'b0;
  end

  AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy); // R9
  AST_STROBE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    port_strobe |-> busy); // R9
  AST_OFFSET_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st != SQ_OFFSET) |=> $stable(offset_q)); // R5
  AST_PEND_CLEAR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> $past(st == SQ_OFFSET && mode_en_q)); // R8
  AST_SKIP_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_IDLE && req_valid && req_enable && !allowed) |=> !port_strobe); // R7
endmodule

// File: tb/tb_dcal_seq.sv
module tb_dcal_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_enable, req_ready;
  logic        adjust_en, table_present, pend_set;
  logic [1:0]  offset_cfg, offset_q;
  logic        busy, done, pending;
  logic [8:0]  port_ctl;
  logic [31:0] port_wdata, port_rdata;
  logic        port_strobe;

  always #10 clk = ~clk;

  dcal_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_enable(req_enable),
    .req_ready(req_ready), .adjust_en(adjust_en), .table_present(table_present),
    .pend_set(pend_set), .offset_cfg(offset_cfg), .busy(busy), .done(done),
    .pending(pending), .offset_q(offset_q), .port_ctl(port_ctl),
    .port_wdata(port_wdata), .port_strobe(port_strobe), .port_rdata(port_rdata)
  );

  // register-file responder
  logic [31:0] raw_word;
  logic [31:0] mem [64];
  logic        unlocked;
  logic        prev_strobe;
  int          strobe_cnt, width_err;
  logic [40:0] log_q [8];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= 32'h0;
      unlocked    <= 1'b0;
      port_rdata  <= 32'hDEAD_BEEF;
      prev_strobe <= 1'b0;
      strobe_cnt  <= 0;
      width_err   <= 0;
    end else begin
      prev_strobe <= port_strobe;
      if (port_strobe && prev_strobe) width_err <= width_err + 1;
      port_rdata <= 32'hDEAD_BEEF;
      if (port_strobe) begin
        log_q[strobe_cnt[2:0]] <= {port_ctl, port_wdata};
        strobe_cnt <= strobe_cnt + 1;
        if (port_ctl[8]) begin
          port_rdata <= (port_ctl[5:0] == 6'h26) ? raw_word : mem[port_ctl[5:0]];
        end else if (port_ctl[5:0] == 6'h00) begin
          unlocked <= (port_wdata == 32'hA500_0000);
        end else if (port_ctl[5:0] == 6'h22) begin
          if (unlocked) mem[6'h22] <= port_wdata;
          unlocked <= 1'b0;
        end else begin
          mem[port_ctl[5:0]] <= port_wdata;
        end
      end
    end
  end

  int n_checks = 0;
  int n_errs   = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [40:0] act, input logic [40:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_manual(input logic [31:0] raw);
    int c, v;
    c = int'(raw[4:0]);
    v = (c * 3) / 4 + 2;
    if (v > 31) v = 31;
    return 8'h80 | 8'(v);
  endfunction

  task automatic request(input logic en);
    @(negedge clk);
    req_valid  = 1'b1;
    req_enable = en;
    @(negedge clk);
    req_valid  = 1'b0;
    chk("R9 busy after accept", {40'h0, busy}, 41'h1);
    chk("R9 ready low while busy", {40'h0, req_ready}, 41'h0);
  endtask

  task automatic wait_done;
    int k;
    k = 0;
    while (!done && k < 200) begin
      @(negedge clk);
      k++;
    end
    chk("R9 done reached", {40'h0, done}, 41'h1);
    chk("R9 busy with done", {40'h0, busy}, 41'h1);
    @(negedge clk);
  endtask

  task automatic pulse_pend;
    @(negedge clk);
    pend_set = 1'b1;
    @(negedge clk);
    pend_set = 1'b0;
  endtask

  localparam int NV = 6;
  localparam logic [31:0] V_RAW [NV] = '{32'h0000_0000, 32'h1234_561F, 32'hFFFF_FFE5,
                                         32'h0000_0010, 32'hABCD_EF0A, 32'h0000_0021};
  localparam logic [1:0]  V_OFF [NV] = '{2'd1, 2'd3, 2'd0, 2'd2, 2'd1, 2'd3};

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    int base;
    rst_n = 1'b0; req_valid = 1'b0; req_enable = 1'b0; pend_set = 1'b0;
    adjust_en = 1'b1; table_present = 1'b1; offset_cfg = 2'd0; raw_word = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 busy", {40'h0, busy}, 41'h0);
    chk("R10 done", {40'h0, done}, 41'h0);
    chk("R10 strobe", {40'h0, port_strobe}, 41'h0);
    chk("R10 pending", {40'h0, pending}, 41'h0);
    chk("R10 offset", {39'h0, offset_q}, 41'h0);
    chk("R10 ready", {40'h0, req_ready}, 41'h1);

    // vector table: enable sequence
    for (int v = 0; v < NV; v++) begin
      raw_word   = V_RAW[v];
      offset_cfg = V_OFF[v];
      pulse_pend();
      chk("R8 pending set", {40'h0, pending}, 41'h1);
      base = strobe_cnt;
      request(1'b1);
      wait_done();
      chk("R3 access count", 41'(strobe_cnt - base), 41'd3);
      chk("R2 strobe width", 41'(width_err), 41'd0);
      chk("R1 R3 unlock access", log_q[(base + 0) % 8], {9'h000, 32'hA500_0000});
      chk("R1 R3 read access ctl", {32'h0, log_q[(base + 1) % 8][40:32]}, {32'h0, 9'h126});
      chk("R1 R3 manual access ctl", {32'h0, log_q[(base + 2) % 8][40:32]}, {32'h0, 9'h022});
      chk("R4 R2 manual value", {9'h0, mem[6'h22]}, {9'h0, 24'h0, exp_manual(V_RAW[v])});
      chk("R5 offset loaded", {39'h0, offset_q}, {39'h0, V_OFF[v]});
      chk("R8 pending cleared", {40'h0, pending}, 41'h0);
    end

    // R6 disable sequence
    base = strobe_cnt;
    request(1'b0);
    wait_done();
    chk("R6 access count", 41'(strobe_cnt - base), 41'd2);
    chk("R6 unlock", log_q[(base + 0) % 8], {9'h000, 32'hA500_0000});
    chk("R6 zero write", log_q[(base + 1) % 8], {9'h022, 32'h0});
    chk("R6 manual cleared", {9'h0, mem[6'h22]}, 41'h0);
    chk("R6 offset cleared", {39'h0, offset_q}, 41'h0);

    // R7 gated: pending clear
    raw_word = 32'h0000_001F; offset_cfg = 2'd3;
    base = strobe_cnt;
    request(1'b1);
    wait_done();
    chk("R7 no access pending low", 41'(strobe_cnt - base), 41'd0);
    chk("R7 offset kept", {39'h0, offset_q}, 41'h0);
    chk("R7 manual kept", {9'h0, mem[6'h22]}, 41'h0);

    // R7 gated: adjustment off
    pulse_pend();
    adjust_en = 1'b0;
    base = strobe_cnt;
    request(1'b1);
    wait_done();
    chk("R7 no access adjust off", 41'(strobe_cnt - base), 41'd0);
    chk("R7 R8 pending kept", {40'h0, pending}, 41'h1);
    chk("R7 offset kept adjust off", {39'h0, offset_q}, 41'h0);

    // R7 gated: table absent
    adjust_en = 1'b1; table_present = 1'b0;
    base = strobe_cnt;
    request(1'b1);
    wait_done();
    chk("R7 no access table absent", 41'(strobe_cnt - base), 41'd0);
    chk("R7 pending kept table absent", {40'h0, pending}, 41'h1);
    table_present = 1'b1;

    // R9 request while busy is dropped
    base = strobe_cnt;
    request(1'b0);
    req_valid = 1'b1; req_enable = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    repeat (30) @(negedge clk);
    chk("R9 busy request dropped", 41'(strobe_cnt - base), 41'd2);
    chk("R9 idle afterwards", {40'h0, busy}, 41'h0);
    chk("R9 pending untouched", {40'h0, pending}, 41'h1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule